// File: doc/BRIEF.md
# Dead-Time Half-Bridge Drive Controller

This block turns a single PWM command bit into two complementary gate-enable outputs for a half-bridge: one for the high-side switch and one for the low-side switch. A high command asks for the high side on and the low side off. A low command asks for the reverse.

Turn-off of either output takes effect one clock after the request goes away. Turn-on waits out a programmable dead time, counted in clock cycles, after the opposite switch has been released. Both sides load the same dead-time count, so the two gaps always match.

An enable input and two synchronous supply-good flags qualify the outputs. The main-supply flag gates both sides. The bootstrap-supply flag gates only the high side. Whenever a side's request returns, whether from the PWM bit, the enable or a flag, that side runs a fresh dead-time count before it turns on.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While rst_ni is low, hs_on_o and ls_on_o are both 0, and pending counts are cleared. After release, the requested side turns on only after a full dead-time count.
- R2: With en_i, main_ok_i and boot_ok_i high, pwm_i=1 commands the high side on and the low side off, and pwm_i=0 commands the low side on and the high side off.
- R3: en_i=0 drives both outputs to 0 at the first clock edge that samples it, and they stay 0 whatever pwm_i does.
- R4: An output whose request drops goes to 0 at the first clock edge that samples the change.
- R5: A side's turn-on comes D+1 clock edges after the first edge that sees its request, where D is dead_cnt_i sampled at that first edge. Later changes to dead_cnt_i do not alter a count already in progress.
- R6: The high side and the low side use the same turn-on delay for the same D.
- R7: main_ok_i=0 drives both outputs to 0 at the next edge and holds them there.
- R8: boot_ok_i=0 drives hs_on_o to 0 at the next edge and blocks it. The low side keeps switching normally.
- R9: With D=0, the incoming output rises on the clock edge right after the edge on which the outgoing output fell.
- R10: If a side's request drops before its count expires, the pending turn-on is cancelled. The next request restarts the full count.
- R11: hs_on_o and ls_on_o are never 1 in the same cycle, and an output rises only if the opposite output was 0 in the cycle before.
- R12: When en_i, main_ok_i or boot_ok_i returns high, an output turns on only after a full D+1 cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command: 1 selects the high side, 0 the low side |
| en_i | input | 1 | Enable; 0 forces both outputs off |
| main_ok_i | input | 1 | Main supply good; 0 blocks both outputs |
| boot_ok_i | input | 1 | Bootstrap supply good; 0 blocks the high side only |
| dead_cnt_i | input | CNT_W | Dead-time count D in clock cycles |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |

## Verification
The command edge is swept in both directions for every dead-time value from 0 to 9, with both outputs sampled on every cycle of each window. This separates an off-by-one in the count, a mismatch between the two sides, and a zero setting that is handled wrongly.

Separate patterns exercise the remaining cases:
- A command reversed in mid-count shows whether the count is cancelled or carried over.
- A dead-time value changed in mid-count shows whether it was sampled at the right moment.
- Dropping and restoring each qualifier separately confirms which side each one blocks.
- Restoring each qualifier confirms that recovery waits for a full count rather than turning on at once.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int NUM_SIDES = 2;
  localparam int HS_IDX    = 0;
  localparam int LS_IDX    = 1;
endpackage

// File: rtl/hb_req_qual.sv
module hb_req_qual
  import hb_pkg::*;
(
  input  logic                 pwm_i,
  input  logic                 en_i,
  input  logic                 main_ok_i,
  input  logic                 boot_ok_i,
  output logic [NUM_SIDES-1:0] req_o
);
  logic common_ok;

  always_comb begin
    common_ok      = en_i & main_ok_i;
    req_o          = '0;
    req_o[HS_IDX]  = common_ok & boot_ok_i & pwm_i;
    req_o[LS_IDX]  = common_ok & ~pwm_i;
  end
endmodule

// File: rtl/hb_leg_timer.sv
module hb_leg_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             opp_on_i,
  input  logic [CNT_W-1:0] dead_i,
  output logic             on_o
);
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!req_i) begin
      // turn-off and cancel are immediate
      on_q   <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!on_q) begin
      if (!pend_q) begin
        pend_q <= 1'b1;
        cnt_q  <= dead_i;
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - CNT_W'(1);
      end else if (!opp_on_i) begin
        on_q   <= 1'b1;
        pend_q <= 1'b0;
      end
    end
  end

  assign on_o = on_q;
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic             en_i,
  input  logic             main_ok_i,
  input  logic             boot_ok_i,
  input  logic [CNT_W-1:0] dead_cnt_i,
  output logic             hs_on_o,
  output logic             ls_on_o
);
  logic [NUM_SIDES-1:0] req;
  logic [NUM_SIDES-1:0] on;

  hb_req_qual u_qual (
    .pwm_i     (pwm_i),
    .en_i      (en_i),
    .main_ok_i (main_ok_i),
    .boot_ok_i (boot_ok_i),
    .req_o     (req)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_leg
    hb_leg_timer #(.CNT_W(CNT_W)) u_leg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (req[s]),
      .opp_on_i (on[NUM_SIDES-1-s]),
      .dead_i   (dead_cnt_i),
      .on_o     (on[s])
    );
  end

  assign hs_on_o = on[HS_IDX];
  assign ls_on_o = on[LS_IDX];
endmodule

// File: rtl/hb_deadtime_ctrl_chk.sv
module hb_deadtime_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_i,
  input logic en_i,
  input logic main_ok_i,
  input logic boot_ok_i,
  input logic hs_on_o,
  input logic ls_on_o
);
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_on_o && ls_on_o)); // R11

  AST_HS_RISE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(!ls_on_o)); // R11

  AST_LS_RISE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_on_o) |-> $past(!hs_on_o)); // R11

  AST_EN_FORCE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!hs_on_o && !ls_on_o)); // R3

  AST_MAIN_FORCE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !main_ok_i |=> (!hs_on_o && !ls_on_o)); // R7

  AST_BOOT_HS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boot_ok_i |=> !hs_on_o); // R8

  AST_HS_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> !hs_on_o); // R4

  AST_LS_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_i |=> !ls_on_o); // R4

  AST_HS_RISE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> $past(pwm_i && en_i && main_ok_i && boot_ok_i)); // R2

  AST_LS_RISE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_on_o) |-> $past(!pwm_i && en_i && main_ok_i)); // R2
endmodule

bind hb_deadtime_ctrl hb_deadtime_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwm_i     (pwm_i),
  .en_i      (en_i),
  .main_ok_i (main_ok_i),
  .boot_ok_i (boot_ok_i),
  .hs_on_o   (hs_on_o),
  .ls_on_o   (ls_on_o)
);

// File: tb/hb_deadtime_ctrl_tb_top.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl_tb_top;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             pwm, en, main_ok, boot_ok;
  logic [CNT_W-1:0] dead;
  logic             hs, ls;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  hb_deadtime_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .pwm_i      (pwm),
    .en_i       (en),
    .main_ok_i  (main_ok),
    .boot_ok_i  (boot_ok),
    .dead_cnt_i (dead),
    .hs_on_o    (hs),
    .ls_on_o    (ls)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // n negedges; an output is expected high from local cycle *_at onward (0 = never)
  task automatic watch(int n, int hs_at, int ls_at, string tag);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      chk({tag, " hs"}, int'(hs), int'(hs_at != 0 && k >= hs_at));
      chk({tag, " ls"}, int'(ls), int'(ls_at != 0 && k >= ls_at));
      chk("R11 overlap", int'(hs && ls), 0);
    end
  endtask

  initial begin
    rst_ni = 1'b0; pwm = 1'b0; en = 1'b1; main_ok = 1'b1; boot_ok = 1'b1;
    dead = CNT_W'(3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1 reset hs", int'(hs), 0);
      chk("R1 reset ls", int'(ls), 0);
    end
    rst_ni = 1'b1;
    watch(5, 0, 5, "R1 R12 post-reset");

    // sweep of dead time, both directions (R2 R4 R5 R6 R9)
    for (int d = 0; d < 10; d++) begin
      dead = CNT_W'(d);
      pwm  = 1'b1;
      watch(d + 2, d + 2, 0, (d == 0) ? "R9 R2 R4 hs" : "R2 R4 R5 hs");
      pwm  = 1'b0;
      watch(d + 2, 0, d + 2, (d == 0) ? "R9 R6 ls" : "R6 R4 R5 ls");
    end

    // R5: dead time sampled at the transition
    dead = CNT_W'(4); pwm = 1'b1;
    watch(1, 0, 0, "R5 sample");
    dead = CNT_W'(0);
    watch(5, 5, 0, "R5 mid-change");
    dead = CNT_W'(0); pwm = 1'b0;
    watch(2, 0, 2, "R5 settle");

    // R10: cancel and restart
    dead = CNT_W'(5); pwm = 1'b1;
    watch(2, 0, 0, "R10 pending");
    pwm = 1'b0;
    watch(7, 0, 7, "R10 cancel");
    pwm = 1'b1;
    watch(7, 7, 0, "R10 restart");

    // R3 / R12 enable
    en = 1'b0;
    watch(1, 0, 0, "R3 en off");
    pwm = 1'b0;
    watch(4, 0, 0, "R3 pwm ignored");
    en = 1'b1;
    watch(7, 0, 7, "R12 en back");

    // R7 / R12 main supply
    main_ok = 1'b0;
    watch(1, 0, 0, "R7 main off");
    pwm = 1'b1;
    watch(3, 0, 0, "R7 held");
    main_ok = 1'b1;
    watch(7, 7, 0, "R12 main back");

    // R8 / R12 bootstrap supply
    boot_ok = 1'b0;
    watch(1, 0, 0, "R8 hs off");
    pwm = 1'b0;
    watch(7, 0, 7, "R8 ls normal");
    pwm = 1'b1;
    watch(4, 0, 0, "R8 hs blocked");
    boot_ok = 1'b1;
    watch(7, 7, 0, "R12 boot back");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule